// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block is the stall and bubble controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no forwarding network. Each cycle it compares the source registers of the instruction sitting in decode against the destination registers that the older instructions in execute, memory and writeback are still going to write. On a match it freezes fetch and decode and sends an empty slot into execute. The dependent instruction stays in decode until its producer has retired.

Conditional branches are compared in the execute stage, so fetch cannot run past a branch. When a branch leaves decode, the unit holds the PC and discards the instruction fetched behind it. In the following cycle it uses the execute stage's taken indication to decide whether the fall-through instruction now being fetched may enter decode or must also be discarded. A one-bit register remembers that a branch has moved into execute. Everything else is combinational on the current cycle's inputs.

Top module: `hazard_interlock`

## Requirements
- R1: A used source (rs1 or rs2) of a valid decode instruction that equals the execute-stage destination while its write-enable is high causes a stall.
- R2: The same match against the memory-stage destination causes a stall.
- R3: With WB_WRITE_FIRST=0 (default), a match against the writeback destination causes a stall. With WB_WRITE_FIRST=1, the writeback stage never causes a stall.
- R4: Register number 0 never creates a dependency, whether it is the source or the destination.
- R5: A stall drives pc_hold=1, ifid_hold=1 and idex_bubble=1 together, with ifid_squash=0.
- R6: No stall arises from a source whose use flag is 0, from an invalid decode slot, from a write-enable of 0, or from unequal register numbers.
- R7: A valid branch in decode with no hazard gives pc_hold=1, ifid_squash=1, ifid_hold=0 and idex_bubble=0.
- R8: Branch sources pass through the same dependency check. A branch with a hazard stalls as in R5 and does not squash.
- R9: In the cycle after a branch leaves decode, pc_hold=0 and ifid_squash equals ex_taken.
- R10: A load followed directly by a dependent instruction costs 3 bubble cycles with WB_WRITE_FIRST=0 and 2 bubble cycles with WB_WRITE_FIRST=1.
- R11: Reset (rst_n low, asynchronous) clears the branch-in-execute state, so that ex_taken has no effect and all outputs are 0 while decode is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_rs1 | input | RW | First source register number |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | RW | Second source register number |
| id_rs2_en | input | 1 | Second source is read |
| ex_rd | input | RW | Execute-stage destination |
| ex_we | input | 1 | Execute-stage write-enable |
| mem_rd | input | RW | Memory-stage destination |
| mem_we | input | 1 | Memory-stage write-enable |
| wb_rd | input | RW | Writeback-stage destination |
| wb_we | input | 1 | Writeback-stage write-enable |
| ex_taken | input | 1 | Branch in execute is taken |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| ifid_squash | output | 1 | Replace the fetched instruction with an empty slot |

## Verification
The hold, bubble and branch-in-decode squash outputs are due in the same cycle as the decode and stage inputs that cause them. The taken squash is due exactly one cycle after the branch leaves decode, because it passes through the single branch register. The bench drives a cycle's inputs at the falling edge and pushes the expected output set for that same cycle. The monitor compares it a quarter period later, well before the next rising edge. The load-use cost is counted over four consecutive cycles while the producer moves through execute, memory and writeback, on both the default instance and a write-first instance.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int RW = 5,
  parameter bit WB_WRITE_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic          id_branch,
  input  logic [RW-1:0] id_rs1,
  input  logic          id_rs1_en,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_rs2_en,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          ex_taken,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_squash
);

  function automatic logic dep(input logic [RW-1:0] src, input logic en,
                               input logic [RW-1:0] dst, input logic we);
    return en && we && (src != '0) && (src == dst);
  endfunction

  logic wb_live;
  logic raw;
  logic br_go;
  logic br_in_ex;

  assign wb_live = wb_we && !WB_WRITE_FIRST;

  assign raw = id_valid && (
      dep(id_rs1, id_rs1_en, ex_rd,  ex_we)   || dep(id_rs2, id_rs2_en, ex_rd,  ex_we)   ||
      dep(id_rs1, id_rs1_en, mem_rd, mem_we)  || dep(id_rs2, id_rs2_en, mem_rd, mem_we)  ||
      dep(id_rs1, id_rs1_en, wb_rd,  wb_live) || dep(id_rs2, id_rs2_en, wb_rd,  wb_live));

  assign br_go = id_valid && id_branch && !raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) br_in_ex <= 1'b0;
    else        br_in_ex <= br_go;

  assign pc_hold     = raw || br_go;
  assign ifid_hold   = raw;
  assign idex_bubble = raw;
  assign ifid_squash = br_go || (br_in_ex && ex_taken);

endmodule

module hazard_interlock_chk (
  input logic clk,
  input logic rst_n,
  input logic id_valid,
  input logic id_branch,
  input logic id_rs1_zero,
  input logic id_rs2_zero,
  input logic ex_taken,
  input logic pc_hold,
  input logic ifid_hold,
  input logic idex_bubble,
  input logic ifid_squash
);

  // R5
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (pc_hold && ifid_hold && !ifid_squash));

  // R5
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold == idex_bubble);

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_rs1_zero && id_rs2_zero) |-> !idex_bubble);

  // R6
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !idex_bubble);

  // R7
  branch_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_branch && !idex_bubble) |-> (pc_hold && ifid_squash));

  // R9
  branch_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_branch && !idex_bubble) |=> (!pc_hold && (ifid_squash == ex_taken)));

endmodule

bind hazard_interlock hazard_interlock_chk chk_i (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_branch(id_branch),
  .id_rs1_zero(id_rs1 == '0), .id_rs2_zero(id_rs2 == '0), .ex_taken(ex_taken),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
  .ifid_squash(ifid_squash));

// File: tb/hazard_interlock_test.sv
module hazard_interlock_test;
  localparam int PERIOD = 12;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid, id_branch, id_rs1_en, id_rs2_en, ex_we, mem_we, wb_we, ex_taken;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic pc_hold, ifid_hold, idex_bubble, ifid_squash;
  logic s_pc_hold, s_ifid_hold, s_idex_bubble, s_ifid_squash;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int which;
    logic [3:0] exp;
  } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  hazard_interlock #(.RW(RW), .WB_WRITE_FIRST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_branch(id_branch),
    .id_rs1(id_rs1), .id_rs1_en(id_rs1_en), .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
    .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .ex_taken(ex_taken),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_squash(ifid_squash));

  hazard_interlock #(.RW(RW), .WB_WRITE_FIRST(1'b1)) uut_split (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_branch(id_branch),
    .id_rs1(id_rs1), .id_rs1_en(id_rs1_en), .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
    .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .ex_taken(ex_taken),
    .pc_hold(s_pc_hold), .ifid_hold(s_ifid_hold), .idex_bubble(s_idex_bubble),
    .ifid_squash(s_ifid_squash));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    id_valid = 0; id_branch = 0; id_rs1 = 0; id_rs1_en = 0; id_rs2 = 0; id_rs2_en = 0;
    ex_rd = 0; ex_we = 0; mem_rd = 0; mem_we = 0; wb_rd = 0; wb_we = 0; ex_taken = 0;
  endtask

  task automatic expect_out(input string tag, input int which, input logic [3:0] exp);
    item_t it;
    it.tag = tag; it.which = which; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic src1(input logic [RW-1:0] r);
    id_valid = 1; id_rs1 = r; id_rs1_en = 1;
  endtask

  initial begin : monitor
    item_t it;
    logic [3:0] act;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      while (q.size() > 0) begin
        it = q.pop_front();
        act = it.which == 0 ? {pc_hold, ifid_hold, idex_bubble, ifid_squash}
                            : {s_pc_hold, s_ifid_hold, s_idex_bubble, s_ifid_squash};
        check(it.tag, int'(act), int'(it.exp));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int nb_def, nb_split;
    cyc(); ex_taken = 1; expect_out("R11 reset outputs", 0, 4'b0000);
    cyc(); rst_n = 1;

    cyc(); src1(3); ex_rd = 3; ex_we = 1; expect_out("R1 rs1 vs ex", 0, 4'b1110);
    cyc(); id_valid = 1; id_rs2 = 9; id_rs2_en = 1; ex_rd = 9; ex_we = 1;
           expect_out("R1 rs2 vs ex", 0, 4'b1110);
    cyc(); src1(12); mem_rd = 12; mem_we = 1; expect_out("R2 rs1 vs mem", 0, 4'b1110);
    cyc(); src1(20); wb_rd = 20; wb_we = 1;
           expect_out("R3 wb stalls default", 0, 4'b1110);
           expect_out("R3 wb ignored write-first", 1, 4'b0000);
    cyc(); src1(0); ex_rd = 0; ex_we = 1; mem_rd = 0; mem_we = 1;
           expect_out("R4 reg0", 0, 4'b0000);
    cyc(); id_valid = 1; id_rs1 = 4; id_rs1_en = 0; ex_rd = 4; ex_we = 1;
           expect_out("R6 unused source", 0, 4'b0000);
    cyc(); id_valid = 0; id_rs1 = 4; id_rs1_en = 1; ex_rd = 4; ex_we = 1;
           expect_out("R6 invalid slot", 0, 4'b0000);
    cyc(); src1(4); ex_rd = 4; ex_we = 0; expect_out("R6 we low", 0, 4'b0000);
    cyc(); src1(4); ex_rd = 5; ex_we = 1; mem_rd = 6; mem_we = 1;
           expect_out("R6 no match", 0, 4'b0000);

    cyc(); id_valid = 1; id_branch = 1; expect_out("R7 branch go", 0, 4'b1001);
    cyc(); ex_taken = 0; expect_out("R9 not taken", 0, 4'b0000);
    cyc(); id_valid = 1; id_branch = 1; expect_out("R7 branch go 2", 0, 4'b1001);
    cyc(); ex_taken = 1; expect_out("R9 taken squash", 0, 4'b0001);

    cyc(); src1(8); id_branch = 1; mem_rd = 8; mem_we = 1; ex_taken = 1;
           expect_out("R8 branch hazard", 0, 4'b1110);
    cyc(); src1(8); id_branch = 1; expect_out("R8 branch released", 0, 4'b1001);
    cyc(); ex_taken = 1; expect_out("R9 taken after stall", 0, 4'b0001);

    nb_def = 0; nb_split = 0;
    cyc(); src1(7); ex_rd = 7; ex_we = 1;
           expect_out("R10 load in ex", 0, 4'b1110);
           #(PERIOD/4); nb_def += int'(idex_bubble); nb_split += int'(s_idex_bubble);
    cyc(); src1(7); mem_rd = 7; mem_we = 1;
           #(PERIOD/4); nb_def += int'(idex_bubble); nb_split += int'(s_idex_bubble);
    cyc(); src1(7); wb_rd = 7; wb_we = 1;
           #(PERIOD/4); nb_def += int'(idex_bubble); nb_split += int'(s_idex_bubble);
    cyc(); src1(7); expect_out("R10 consumer proceeds", 0, 4'b0000);
           #(PERIOD/4); nb_def += int'(idex_bubble); nb_split += int'(s_idex_bubble);
    check("R10 bubbles default", nb_def, 3);
    check("R10 bubbles write-first", nb_split, 2);

    cyc(); id_valid = 1; id_branch = 1; expect_out("R7 branch before reset", 0, 4'b1001);
    cyc(); rst_n = 0; ex_taken = 1; expect_out("R11 reset clears branch", 0, 4'b0000);
    cyc(); rst_n = 1;
    cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule